// File: doc/BRIEF.md
# Speculation-Aware Return Address Guard

This block guards subroutine return targets against corruption of the in-memory stack. Ahead of each call, the pipeline sends a call-check event that carries the return address the call will produce. The block pushes that address onto a private hardware stack. Ahead of each return, the pipeline sends a return-check event. The block then waits until the execute stage reports the return target it computed. It compares that target with the top of the stack and reports whether the two agree. A disagreement flags a possible overwrite of the return address.

The pipeline runs ahead speculatively, so the block keeps two stacks. The shadow stack follows the check events as they arrive and serves every comparison. The committed stack changes only when the commit stage retires a call, which pushes, or a return, which pops. On a misspeculation the shadow stack is rebuilt from the committed stack, so that addresses pushed on a squashed path vanish.

Both stacks have a fixed depth. When a push arrives with a stack already full, the oldest entry is lost and a sticky overflow flag is raised.

Top module: `srs_guard`

## Requirements
- R1: After reset, res_vld and ovf_flag are 0, no return check is pending, and both stacks are empty.
- R2: A call check pushes its address onto the shadow stack. A pending return check followed by an execute target equal to the shadow top yields res_vld=1 with res_bad=0 and pops that entry, so nested calls are matched in last-in first-out order.
- R3: When the execute target differs from the shadow top, the result has res_vld=1 and res_bad=1, and the top entry is still popped.
- R4: An execute target is compared only while a return check is pending. A target with no pending check produces no result and leaves the shadow stack unchanged. A pending check produces no result until its target arrives.
- R5: A return check compared against an empty shadow stack reports res_bad=1.
- R6: A misspeculation in cycle k makes the shadow stack equal to the committed stack as updated in cycle k, which includes a commit in that same cycle. It also cancels any pending return check, and it overrides the check events of cycle k.
- R7: The committed stack is pushed only by a committed call (cmt_call_vld, with its address) and popped only by a committed return (cmt_ret_vld). Check events never change it.
- R8: A push onto a full stack (DEPTH entries) discards the oldest entry and keeps the newest DEPTH. It sets ovf_flag, which stays 1 until reset.
- R9: Each comparison gives exactly one result, with res_vld high for one cycle in the cycle after the target is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| chk_call_vld | input | 1 | Call-check event |
| chk_call_addr | input | AW | Expected return address of the checked call |
| chk_ret_vld | input | 1 | Return-check event; arms the wait for a target |
| exe_tgt_vld | input | 1 | Execute stage reports a return target |
| exe_tgt_addr | input | AW | Return target computed by the execute stage |
| cmt_call_vld | input | 1 | A call has committed |
| cmt_call_addr | input | AW | Return address of the committed call |
| cmt_ret_vld | input | 1 | A return has committed |
| misspec | input | 1 | Misspeculation: rebuild shadow stack from committed stack |
| res_vld | output | 1 | Comparison result valid (one-cycle pulse) |
| res_bad | output | 1 | Target did not match, or the stack was empty |
| ovf_flag | output | 1 | Sticky stack overflow flag |

## Verification
The bench builds the block with DEPTH=4 and AW=16. A depth of four lets five nested calls reach the overflow case, where the oldest entry is dropped, within a few dozen cycles. Sixteen-bit addresses are wide enough to give each stack level a distinct value. The small depth also makes it cheap to empty the stack on purpose, both to reach the empty-stack mismatch and to confirm that a rebuild from the committed stack removes speculative entries. One stimulus drives a commit and a misspeculation in the same cycle, to show that the rebuild uses the updated committed stack.

// File: rtl/srs_pkg.sv
package srs_pkg;
  typedef enum logic {
    RC_IDLE = 1'b0,
    RC_WAIT = 1'b1
  } rc_state_e;
endpackage

// File: rtl/srs_lifo.sv
module srs_lifo #(
  parameter int DEPTH = 8,
  parameter int AW    = 32,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      load,
  input  logic [DEPTH-1:0][AW-1:0]  ld_ent,
  input  logic [CW-1:0]             ld_cnt,
  input  logic                      push,
  input  logic [AW-1:0]             push_addr,
  input  logic                      pop,
  output logic [DEPTH-1:0][AW-1:0]  ent_q,
  output logic [CW-1:0]             cnt_q,
  output logic                      drop
);
  localparam logic [CW-1:0] FULL = CW'(DEPTH);

  logic [DEPTH-1:0][AW-1:0] base_ent, ent_d;
  logic [CW-1:0]            base_cnt, cnt_d;
  logic                     upd;

  // load happens first; push and pop of the same cycle apply on top of it
  always_comb begin
    base_ent = load ? ld_ent : ent_q;
    base_cnt = load ? ld_cnt : cnt_q;
    ent_d    = base_ent;
    cnt_d    = base_cnt;
    drop     = 1'b0;
    if (push && pop) begin
      ent_d[0] = push_addr;
      if (base_cnt == '0) cnt_d = CW'(1);
    end else if (push) begin
      for (int i = 1; i < DEPTH; i++) ent_d[i] = base_ent[i-1];
      ent_d[0] = push_addr;
      if (base_cnt == FULL) drop = 1'b1;
      else                  cnt_d = base_cnt + CW'(1);
    end else if (pop && (base_cnt != '0)) begin
      for (int i = 0; i < DEPTH - 1; i++) ent_d[i] = base_ent[i+1];
      ent_d[DEPTH-1] = '0;
      cnt_d = base_cnt - CW'(1);
    end
  end

  assign upd = load | push | pop;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ent_q <= '0;
      cnt_q <= '0;
    end else if (upd) begin
      ent_q <= ent_d;
      cnt_q <= cnt_d;
    end
  end
endmodule

// File: rtl/srs_retchk.sv
module srs_retchk
  import srs_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ret_chk,
  input  logic          tgt_vld,
  input  logic [AW-1:0] tgt_addr,
  input  logic          flush,
  input  logic [AW-1:0] top_addr,
  input  logic          top_ok,
  output logic          waiting,
  output logic          cmp,
  output logic          res_vld,
  output logic          res_bad
);
  rc_state_e st_q, st_d;
  logic      bad_d;

  assign waiting = (st_q == RC_WAIT);
  assign cmp     = waiting & tgt_vld & ~flush;
  assign bad_d   = ~top_ok | (tgt_addr != top_addr);

  always_comb begin
    st_d = st_q;
    if (flush)        st_d = RC_IDLE;
    else if (ret_chk) st_d = RC_WAIT;
    else if (cmp)     st_d = RC_IDLE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= RC_IDLE;
      res_vld <= 1'b0;
      res_bad <= 1'b0;
    end else begin
      st_q    <= st_d;
      res_vld <= cmp;
      res_bad <= cmp & bad_d;
    end
  end
endmodule

// File: rtl/srs_guard.sv
module srs_guard #(
  parameter int DEPTH = 8,
  parameter int AW    = 32,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          chk_call_vld,
  input  logic [AW-1:0] chk_call_addr,
  input  logic          chk_ret_vld,
  input  logic          exe_tgt_vld,
  input  logic [AW-1:0] exe_tgt_addr,
  input  logic          cmt_call_vld,
  input  logic [AW-1:0] cmt_call_addr,
  input  logic          cmt_ret_vld,
  input  logic          misspec,
  output logic          res_vld,
  output logic          res_bad,
  output logic          ovf_flag
);
  logic [DEPTH-1:0][AW-1:0] shd_ent_q, real_ent_q;
  logic [CW-1:0]            shd_cnt_q, real_cnt_q;
  logic                     shd_drop, real_drop;
  logic                     shd_push, shd_pop, cmp, waiting;
  logic [AW-1:0]            shd_push_addr;
  logic                     ovf_d;

  // on a flush the shadow replays this cycle's commit on top of the copy
  assign shd_push      = misspec ? cmt_call_vld  : chk_call_vld;
  assign shd_push_addr = misspec ? cmt_call_addr : chk_call_addr;
  assign shd_pop       = misspec ? cmt_ret_vld   : cmp;

  srs_lifo #(.DEPTH(DEPTH), .AW(AW)) u_shadow (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (misspec),
    .ld_ent    (real_ent_q),
    .ld_cnt    (real_cnt_q),
    .push      (shd_push),
    .push_addr (shd_push_addr),
    .pop       (shd_pop),
    .ent_q     (shd_ent_q),
    .cnt_q     (shd_cnt_q),
    .drop      (shd_drop)
  );

  srs_lifo #(.DEPTH(DEPTH), .AW(AW)) u_real (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (1'b0),
    .ld_ent    ('0),
    .ld_cnt    ('0),
    .push      (cmt_call_vld),
    .push_addr (cmt_call_addr),
    .pop       (cmt_ret_vld),
    .ent_q     (real_ent_q),
    .cnt_q     (real_cnt_q),
    .drop      (real_drop)
  );

  srs_retchk #(.AW(AW)) u_retchk (
    .clk      (clk),
    .rst_n    (rst_n),
    .ret_chk  (chk_ret_vld),
    .tgt_vld  (exe_tgt_vld),
    .tgt_addr (exe_tgt_addr),
    .flush    (misspec),
    .top_addr (shd_ent_q[0]),
    .top_ok   (shd_cnt_q != '0),
    .waiting  (waiting),
    .cmp      (cmp),
    .res_vld  (res_vld),
    .res_bad  (res_bad)
  );

  assign ovf_d = ovf_flag | shd_drop | real_drop;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ovf_flag <= 1'b0;
    else        ovf_flag <= ovf_d;
  end
endmodule

// File: rtl/srs_guard_sva.sv
module srs_guard_sva #(
  parameter int DEPTH = 8,
  parameter int AW    = 32,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     misspec,
  input logic                     exe_tgt_vld,
  input logic                     cmt_call_vld,
  input logic                     cmt_ret_vld,
  input logic                     res_vld,
  input logic                     res_bad,
  input logic                     ovf_flag,
  input logic                     waiting,
  input logic [DEPTH-1:0][AW-1:0] shd_ent,
  input logic [DEPTH-1:0][AW-1:0] real_ent,
  input logic [CW-1:0]            shd_cnt,
  input logic [CW-1:0]            real_cnt
);
  assert_ovf_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_flag |=> ovf_flag);

  assert_res_follows_tgt_R9: assert property (@(posedge clk) disable iff (!rst_n)
    res_vld |-> ($past(exe_tgt_vld) && $past(waiting)));

  assert_idle_tgt_ignored_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (exe_tgt_vld && !waiting) |=> !res_vld);

  assert_empty_is_bad_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (waiting && exe_tgt_vld && !misspec && shd_cnt == '0) |=> (res_vld && res_bad));

  assert_flush_copies_R6: assert property (@(posedge clk) disable iff (!rst_n)
    misspec |=> (shd_cnt == real_cnt && shd_ent == real_ent && !waiting));

  assert_real_only_commit_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!cmt_call_vld && !cmt_ret_vld) |=> ($stable(real_cnt) && $stable(real_ent)));
endmodule

bind srs_guard srs_guard_sva #(.DEPTH(DEPTH), .AW(AW)) u_sva (
  .clk          (clk),
  .rst_n        (rst_n),
  .misspec      (misspec),
  .exe_tgt_vld  (exe_tgt_vld),
  .cmt_call_vld (cmt_call_vld),
  .cmt_ret_vld  (cmt_ret_vld),
  .res_vld      (res_vld),
  .res_bad      (res_bad),
  .ovf_flag     (ovf_flag),
  .waiting      (waiting),
  .shd_ent      (shd_ent_q),
  .real_ent     (real_ent_q),
  .shd_cnt      (shd_cnt_q),
  .real_cnt     (real_cnt_q)
);

// File: tb/srs_guard_tb.sv
module srs_guard_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH      = 4;
  localparam int AW         = 16;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          chk_call_vld = 1'b0;
  logic [AW-1:0] chk_call_addr = '0;
  logic          chk_ret_vld = 1'b0;
  logic          exe_tgt_vld = 1'b0;
  logic [AW-1:0] exe_tgt_addr = '0;
  logic          cmt_call_vld = 1'b0;
  logic [AW-1:0] cmt_call_addr = '0;
  logic          cmt_ret_vld = 1'b0;
  logic          misspec = 1'b0;
  logic          res_vld, res_bad, ovf_flag;

  int  n_run  = 0;
  int  n_fail = 0;
  bit  done   = 1'b0;
  bit  exp_q[$];
  string tag_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  srs_guard #(.DEPTH(DEPTH), .AW(AW)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .chk_call_vld(chk_call_vld), .chk_call_addr(chk_call_addr),
    .chk_ret_vld(chk_ret_vld),
    .exe_tgt_vld(exe_tgt_vld), .exe_tgt_addr(exe_tgt_addr),
    .cmt_call_vld(cmt_call_vld), .cmt_call_addr(cmt_call_addr),
    .cmt_ret_vld(cmt_ret_vld), .misspec(misspec),
    .res_vld(res_vld), .res_bad(res_bad), .ovf_flag(ovf_flag)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // scoreboard monitor: every result pops one expected mismatch bit
  always @(negedge clk) begin
    if (rst_n && res_vld && !done) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R4", "result with nothing expected", 1, 0);
      end else begin
        automatic bit    e = exp_q.pop_front();
        automatic string t = tag_q.pop_front();
        check(res_bad == e, t, "res_bad", res_bad, e);
      end
    end
  end

  task automatic do_call(input logic [AW-1:0] a);
    @(negedge clk); chk_call_vld = 1'b1; chk_call_addr = a;
    @(negedge clk); chk_call_vld = 1'b0;
  endtask

  task automatic do_ret();
    @(negedge clk); chk_ret_vld = 1'b1;
    @(negedge clk); chk_ret_vld = 1'b0;
  endtask

  task automatic do_cmt_call(input logic [AW-1:0] a);
    @(negedge clk); cmt_call_vld = 1'b1; cmt_call_addr = a;
    @(negedge clk); cmt_call_vld = 1'b0;
  endtask

  task automatic do_cmt_ret();
    @(negedge clk); cmt_ret_vld = 1'b1;
    @(negedge clk); cmt_ret_vld = 1'b0;
  endtask

  task automatic do_flush();
    @(negedge clk); misspec = 1'b1;
    @(negedge clk); misspec = 1'b0;
  endtask

  // kind: 0 = no result expected, 1 = match expected, 2 = mismatch expected
  task automatic do_tgt(input logic [AW-1:0] a, input int kind, input string req);
    @(negedge clk); exe_tgt_vld = 1'b1; exe_tgt_addr = a;
    if (kind != 0) begin
      exp_q.push_back(kind == 2);
      tag_q.push_back(req);
    end
    @(negedge clk); exe_tgt_vld = 1'b0;
    check(res_vld == (kind != 0), (kind != 0) ? "R9" : "R4",
          "res_vld one cycle after target", res_vld, kind != 0);
    @(negedge clk);
    check(res_vld == 1'b0, "R9", "res_vld pulse ends", res_vld, 0);
  endtask

  initial begin
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check(res_vld == 1'b0, "R1", "res_vld in reset", res_vld, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(res_vld == 1'b0, "R1", "res_vld after reset", res_vld, 0);
    check(ovf_flag == 1'b0, "R1", "ovf_flag after reset", ovf_flag, 0);
    do_tgt(16'h0777, 0, "R1");                 // nothing pending after reset
    do_ret(); do_tgt(16'h0001, 2, "R1");       // stack empty after reset

    // R2 nested LIFO matching
    do_call(16'h1100); do_call(16'h2200);
    do_ret(); do_tgt(16'h2200, 1, "R2");
    do_ret(); do_tgt(16'h1100, 1, "R2");

    // R3 wrong target, entry still consumed
    do_call(16'h3300);
    do_ret(); do_tgt(16'h3301, 2, "R3");
    // R5 empty stack
    do_ret(); do_tgt(16'h3300, 2, "R5");

    // R4 stray target ignored; pending check waits
    do_call(16'h4400);
    do_tgt(16'h4400, 0, "R4");
    do_ret();
    repeat (4) begin
      @(negedge clk);
      check(res_vld == 1'b0, "R4", "no result while waiting", res_vld, 0);
    end
    do_tgt(16'h4400, 1, "R4");
    do_tgt(16'h4400, 0, "R4");

    // R6 / R7 flush restores committed stack, speculative pushes vanish
    do_cmt_call(16'h5500);
    do_call(16'h6601); do_call(16'h6602);
    do_flush();
    do_ret(); do_tgt(16'h5500, 1, "R6");
    do_ret(); do_tgt(16'h6601, 2, "R7");
    do_cmt_ret();
    do_flush();
    do_ret(); do_tgt(16'h5500, 2, "R7");

    // R6 flush cancels a pending check
    do_call(16'h7700);
    do_ret();
    do_flush();
    do_tgt(16'h7700, 0, "R6");
    do_ret(); do_tgt(16'h7700, 2, "R6");

    // R6 commit in the flush cycle is included
    @(negedge clk); cmt_call_vld = 1'b1; cmt_call_addr = 16'h8800; misspec = 1'b1;
    @(negedge clk); cmt_call_vld = 1'b0; misspec = 1'b0;
    do_ret(); do_tgt(16'h8800, 1, "R6");
    do_cmt_ret(); do_flush();

    // R8 overflow drops oldest, sticky flag
    check(ovf_flag == 1'b0, "R8", "ovf_flag before overflow", ovf_flag, 0);
    for (int i = 1; i <= DEPTH + 1; i++) do_call(AW'(16'h9000 + i));
    check(ovf_flag == 1'b1, "R8", "ovf_flag after overflow", ovf_flag, 1);
    for (int i = DEPTH + 1; i >= 2; i--) begin
      do_ret(); do_tgt(AW'(16'h9000 + i), 1, "R8");
    end
    do_ret(); do_tgt(16'h9001, 2, "R8");
    check(ovf_flag == 1'b1, "R8", "ovf_flag sticky", ovf_flag, 1);

    repeat (2) @(negedge clk);
    check(exp_q.size() == 0, "R9", "results outstanding", exp_q.size(), 0);
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_run++; n_fail++;
      $display("FAIL R1 watchdog expired: actual %0d expected %0d", 1, 0);
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule